// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block is the digital sequencer of a capacitive touch sensor. It runs charge-transfer cycles on eight sensing groups at the same time and counts the transfer pulses each group needs before its sampling comparator input goes high. That count is the touch measurement. The system clock is divided down to a pulse-generator clock. Each transfer pulse is a high phase followed by a low phase, and each phase is a programmable number of pulse-generator cycles long. The output `ctPulse` is high during the high phase, and the analog front end uses it to drive the electrodes.

Software sets the block up through a simple register port: a write strobe plus a combinational read-back. It picks which groups take part, writes the phase lengths, the divider and the count ceiling, then sets the start bit. An acquisition can start at once, or it can wait for a chosen condition on an external sync input. It ends in one of two ways. The end-of-acquisition flag is set when every enabled group has finished. The max-count-error flag is set when some group reaches the ceiling first. Either flag can raise `irq`.

Register map (word addresses):
- Address 0, control: bit 0 enable, bit 1 start (reads back as busy), bit 2 sync mode, bit 3 sync polarity, bits 6:4 divider code, bits 10:7 high length minus one, bits 14:11 low length minus one, bits 17:15 ceiling code.
- Address 1, interrupt enables: bit 0 end-of-acquisition, bit 1 max-count error.
- Address 2, flags (read only): bit 0 end-of-acquisition, bit 1 max-count error.
- Address 3, flag clear (write only): same bit positions as the flags.
- Address 4, groups: bits 7:0 enable mask, bits 23:16 completion bits (read only).
- Addresses 8 + g: the count of group g.

Top module: `ct_touch_seq`

## Requirements
- R1: After reset, every readable register reads 0, and `irq` and `ctPulse` are low.
- R2: Each pulse stays high for (high field + 1) × D system cycles and then low for (low field + 1) × D cycles. D is 2 raised to the divider code (codes 0 to 7 give divide by 1 to 128).
- R3: For each enabled group, the count register holds the number of transfer pulses that ended while that group's sample input was low. The group's completion bit, at bit 16 + g of the group register, is set once a pulse ends with its sample input high.
- R4: The ceiling is 2^(8+c) − 1 for ceiling code c from 0 to 6 (255 up to 16383); code 7 acts as code 6. If any enabled group's count reaches the ceiling, every group stops, the max-count-error flag is set, the start bit clears, and groups that had not finished stay incomplete.
- R5: When every enabled group has completed, the end-of-acquisition flag is set and the start bit clears. Disabled groups are ignored: they keep count 0 and completion 0. An empty mask ends the acquisition at once with this flag.
- R6: With sync mode 0, the acquisition starts as soon as a write to the control register sets the enable and start bits.
- R7: With sync mode 1 and polarity 0, the acquisition starts only on a falling edge of `syncIn`. A steady high level does not start it.
- R8: With sync mode 1 and polarity 1, the acquisition starts while `syncIn` is high, which includes a rising edge.
- R9: A start write is refused, and nothing runs, if the divider code is 0 and the low field is 1 or less, or if the divider code is 1 and the low field is 0.
- R10: Writing 1 to a bit of the clear register clears the matching flag. Writing 0 to a bit leaves its flag unchanged.
- R11: `irq` is high exactly when a set flag has its interrupt enable set.
- R12: Clearing the enable bit during an acquisition stops it, returns the start bit to 0, and sets neither flag.
- R13: Starting a new acquisition clears all counts and completion bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| syncIn | input | 1 | External acquisition sync input |
| sampleIn | input | 8 | Per-group sampling comparator inputs |
| ctPulse | output | 1 | High during the high phase of each transfer pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks per-group thresholds against the ceiling boundary. This includes a group that completes on the very pulse where another group overflows. A design that checks overflow before completion, or that stops one pulse late, would mark the wrong completion bits or report counts that are off by one. The bench holds `syncIn` at a static level before the start write in both polarities. A design that treats a level as an edge would start early, and one that misses the level would hang. Other cases cover an empty mask, both forbidden divider and low-phase pairs, and an abort in the middle of a run. A design that finishes late, runs an illegal configuration, or raises a flag on abort would leave the wrong flags or a changing pulse count.

// File: rtl/ct_touch_pkg.sv
package ct_touch_pkg;

  // Register word addresses
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_IEN      = 1;
  localparam int ADDR_FLAG     = 2;
  localparam int ADDR_CLR      = 3;
  localparam int ADDR_GRP      = 4;
  localparam int ADDR_CNT_BASE = 8;

  // Control register bit positions
  localparam int B_EN    = 0;
  localparam int B_START = 1;
  localparam int B_SMODE = 2;
  localparam int B_SPOL  = 3;
  localparam int B_DIV   = 4;
  localparam int B_HI    = 7;
  localparam int B_LO    = 11;
  localparam int B_MAX   = 15;

  // Completion bits of the group register start here
  localparam int B_DONE  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } acqState_t;

  // Strobes from control to datapath and register file
  typedef struct packed {
    logic clearCounts;
    logic pulseEnd;
    logic setEoa;
    logic setMce;
  } acqStrobe_t;

  // Divider and low-phase pairs that are too short are rejected
  function automatic logic cfgLegal(input logic [2:0] divCode, input logic [3:0] loField);
    return !(((divCode == 3'd0) && (loField <= 4'd1)) ||
             ((divCode == 3'd1) && (loField == 4'd0)));
  endfunction

  // Ceiling is 2^(8+code)-1, code 7 behaves like code 6
  function automatic logic [31:0] ceilingFor(input logic [2:0] code);
    logic [2:0] sh;
    sh = (code > 3'd6) ? 3'd6 : code;
    return (32'd256 << sh) - 32'd1;
  endfunction

endpackage

// File: rtl/ct_touch_regs.sv
module ct_touch_regs
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 14,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        busy,
  input  acqStrobe_t                  strobe,
  input  logic [NUM_GROUPS-1:0]       grpDone,
  input  logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat,
  output logic                        enable,
  output logic                        syncMode,
  output logic                        syncPol,
  output logic [2:0]                  pgDiv,
  output logic [3:0]                  hiLen,
  output logic [3:0]                  loLen,
  output logic [2:0]                  maxCode,
  output logic [NUM_GROUPS-1:0]       grpMask,
  output logic                        startReq,
  output logic                        eoaFlag,
  output logic                        mceFlag,
  output logic                        eoaIe,
  output logic                        mceIe,
  output logic                        irq,
  output logic [DATA_W-1:0]           rdData
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADDR_IEN);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADDR_CLR);
  localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(ADDR_GRP);

  logic wrCtrl, wrIen, wrClr, wrGrp;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrIen  = wrEn && (addr == A_IEN);
  assign wrClr  = wrEn && (addr == A_CLR);
  assign wrGrp  = wrEn && (addr == A_GRP);

  assign startReq = wrCtrl && wrData[B_EN] && wrData[B_START] && !busy &&
                    cfgLegal(wrData[B_DIV +: 3], wrData[B_LO +: 4]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      syncMode <= 1'b0;
      syncPol  <= 1'b0;
      pgDiv    <= '0;
      hiLen    <= '0;
      loLen    <= '0;
      maxCode  <= '0;
      grpMask  <= '0;
      eoaIe    <= 1'b0;
      mceIe    <= 1'b0;
      eoaFlag  <= 1'b0;
      mceFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enable   <= wrData[B_EN];
        syncMode <= wrData[B_SMODE];
        syncPol  <= wrData[B_SPOL];
        pgDiv    <= wrData[B_DIV +: 3];
        hiLen    <= wrData[B_HI +: 4];
        loLen    <= wrData[B_LO +: 4];
        maxCode  <= wrData[B_MAX +: 3];
      end
      if (wrIen) begin
        eoaIe <= wrData[0];
        mceIe <= wrData[1];
      end
      if (wrGrp) grpMask <= wrData[NUM_GROUPS-1:0];
      // a set strobe wins over a clear in the same cycle
      eoaFlag <= strobe.setEoa || (eoaFlag && !(wrClr && wrData[0]));
      mceFlag <= strobe.setMce || (mceFlag && !(wrClr && wrData[1]));
    end
  end

  assign irq = (eoaFlag && eoaIe) || (mceFlag && mceIe);

  always_comb begin
    rdData = '0;
    if (addr == A_CTRL) begin
      rdData[B_EN]       = enable;
      rdData[B_START]    = busy;
      rdData[B_SMODE]    = syncMode;
      rdData[B_SPOL]     = syncPol;
      rdData[B_DIV +: 3] = pgDiv;
      rdData[B_HI +: 4]  = hiLen;
      rdData[B_LO +: 4]  = loLen;
      rdData[B_MAX +: 3] = maxCode;
    end else if (addr == A_IEN) begin
      rdData[0] = eoaIe;
      rdData[1] = mceIe;
    end else if (addr == A_FLAG) begin
      rdData[0] = eoaFlag;
      rdData[1] = mceFlag;
    end else if (addr == A_GRP) begin
      rdData[NUM_GROUPS-1:0]         = grpMask;
      rdData[B_DONE +: NUM_GROUPS]   = grpDone;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (addr == ADDR_W'(ADDR_CNT_BASE + g))
          rdData[CNT_W-1:0] = grpCountFlat[g*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/ct_touch_ctrl.sv
module ct_touch_ctrl
  import ct_touch_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startReq,
  input  logic       syncMode,
  input  logic       syncPol,
  input  logic       syncIn,
  input  logic [2:0] pgDiv,
  input  logic [3:0] hiLen,
  input  logic [3:0] loLen,
  input  logic       allDoneNxt,
  input  logic       anyMaxNxt,
  output logic       busy,
  output logic       ctPulse,
  output acqStrobe_t strobe
);

  acqState_t        state, stateNxt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMask;
  logic [3:0]       phCnt;
  logic             phaseHigh;
  logic             syncQ;
  logic             tick;
  logic             trig;
  logic             running;

  assign divMask = PRE_W'((32'd1 << pgDiv) - 32'd1);
  assign tick    = (preCnt == divMask);
  assign trig    = syncPol ? syncIn : (syncQ && !syncIn);
  assign busy    = (state != ST_IDLE);
  assign ctPulse = (state == ST_RUN) && phaseHigh;

  always_comb begin
    stateNxt           = state;
    strobe             = '0;
    strobe.pulseEnd    = (state == ST_RUN) && enable && tick && !phaseHigh && (phCnt == loLen);
    if (startReq) begin
      stateNxt           = ST_WAIT;
      strobe.clearCounts = 1'b1;
    end else if (!enable) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_WAIT: if (!syncMode || trig) stateNxt = ST_RUN;
        ST_RUN: begin
          if (anyMaxNxt) begin
            stateNxt      = ST_IDLE;
            strobe.setMce = 1'b1;
          end else if (allDoneNxt) begin
            stateNxt      = ST_IDLE;
            strobe.setEoa = 1'b1;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  assign running = (state == ST_RUN) && (stateNxt == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      syncQ     <= 1'b0;
      preCnt    <= '0;
      phCnt     <= '0;
      phaseHigh <= 1'b1;
    end else begin
      state <= stateNxt;
      syncQ <= syncIn;
      if (!running) begin
        preCnt    <= '0;
        phCnt     <= '0;
        phaseHigh <= 1'b1;
      end else if (tick) begin
        preCnt <= '0;
        if (phaseHigh) begin
          if (phCnt == hiLen) begin
            phaseHigh <= 1'b0;
            phCnt     <= '0;
          end else begin
            phCnt <= phCnt + 4'd1;
          end
        end else begin
          if (phCnt == loLen) begin
            phaseHigh <= 1'b1;
            phCnt     <= '0;
          end else begin
            phCnt <= phCnt + 4'd1;
          end
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/ct_touch_dp.sv
module ct_touch_dp
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 14
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  acqStrobe_t                  strobe,
  input  logic [NUM_GROUPS-1:0]       grpMask,
  input  logic [NUM_GROUPS-1:0]       sampleIn,
  input  logic [2:0]                  maxCode,
  output logic [NUM_GROUPS-1:0]       grpDone,
  output logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat,
  output logic                        allDoneNxt,
  output logic                        anyMaxNxt
);

  logic [CNT_W-1:0]      ceiling;
  logic [NUM_GROUPS-1:0] doneNxt;
  logic [NUM_GROUPS-1:0] maxNxt;

  assign ceiling = CNT_W'(ceilingFor(maxCode));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [CNT_W-1:0] cntQ, cntN;
    logic             doneQ, maxQ;
    logic             active;

    assign active = strobe.pulseEnd && grpMask[g] && !doneQ && !maxQ;

    always_comb begin
      cntN       = cntQ;
      doneNxt[g] = doneQ;
      maxNxt[g]  = maxQ;
      if (strobe.clearCounts) begin
        cntN       = '0;
        doneNxt[g] = 1'b0;
        maxNxt[g]  = 1'b0;
      end else if (active) begin
        if (sampleIn[g]) begin
          doneNxt[g] = 1'b1;
        end else begin
          cntN = cntQ + CNT_W'(1);
          if (cntN == ceiling) maxNxt[g] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        doneQ <= 1'b0;
        maxQ  <= 1'b0;
      end else begin
        cntQ  <= cntN;
        doneQ <= doneNxt[g];
        maxQ  <= maxNxt[g];
      end
    end

    assign grpDone[g]                     = doneQ;
    assign grpCountFlat[g*CNT_W +: CNT_W] = cntQ;
  end

  assign allDoneNxt = &(doneNxt | ~grpMask);
  assign anyMaxNxt  = |maxNxt;

endmodule

// File: rtl/ct_touch_seq.sv
module ct_touch_seq
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 14,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int PRE_W      = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  syncIn,
  input  logic [NUM_GROUPS-1:0] sampleIn,
  output logic                  ctPulse,
  output logic                  irq
);

  acqStrobe_t                  strobe;
  logic                        busy, enable, syncMode, syncPol, startReq;
  logic [2:0]                  pgDiv, maxCode;
  logic [3:0]                  hiLen, loLen;
  logic [NUM_GROUPS-1:0]       grpMask, grpDone;
  logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat;
  logic                        eoaFlag, mceFlag, eoaIe, mceIe;
  logic                        allDoneNxt, anyMaxNxt;

  ct_touch_regs #(
    .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .strobe(strobe), .grpDone(grpDone), .grpCountFlat(grpCountFlat),
    .enable(enable), .syncMode(syncMode), .syncPol(syncPol), .pgDiv(pgDiv),
    .hiLen(hiLen), .loLen(loLen), .maxCode(maxCode), .grpMask(grpMask),
    .startReq(startReq), .eoaFlag(eoaFlag), .mceFlag(mceFlag),
    .eoaIe(eoaIe), .mceIe(mceIe), .irq(irq), .rdData(rdData)
  );

  ct_touch_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
    .syncMode(syncMode), .syncPol(syncPol), .syncIn(syncIn),
    .pgDiv(pgDiv), .hiLen(hiLen), .loLen(loLen),
    .allDoneNxt(allDoneNxt), .anyMaxNxt(anyMaxNxt),
    .busy(busy), .ctPulse(ctPulse), .strobe(strobe)
  );

  ct_touch_dp #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grpMask(grpMask),
    .sampleIn(sampleIn), .maxCode(maxCode), .grpDone(grpDone),
    .grpCountFlat(grpCountFlat), .allDoneNxt(allDoneNxt), .anyMaxNxt(anyMaxNxt)
  );

endmodule

// File: rtl/ct_touch_chk.sv
module ct_touch_chk #(
  parameter int NUM_GROUPS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busy,
  input logic                  enable,
  input logic                  startReq,
  input logic                  ctPulse,
  input logic                  irq,
  input logic                  eoaFlag,
  input logic                  mceFlag,
  input logic                  eoaIe,
  input logic                  mceIe,
  input logic [NUM_GROUPS-1:0] grpDone
);

  // R12: a cleared enable returns the sequencer to idle on the next cycle
  a_r12_abort_idles: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !startReq) |=> !busy);

  // R12: an abort raises neither flag
  a_r12_abort_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !enable) |-> (!$rose(eoaFlag) && !$rose(mceFlag)));

  // R2: no transfer pulse outside an acquisition
  a_r2_no_pulse_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ctPulse);

  // R4, R5: a flag is raised only as the acquisition ends
  a_r5_flag_ends_acq: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eoaFlag) || $rose(mceFlag)) |-> $fell(busy));

  // R4: an acquisition has one outcome
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(eoaFlag) && $rose(mceFlag)));

  // R11: masked flags never interrupt
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!eoaIe && !mceIe) |-> !irq);

  // R3: completion bits do not move while idle
  a_r3_done_frozen_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(grpDone));

endmodule

bind ct_touch_seq ct_touch_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .enable(enable), .startReq(startReq),
  .ctPulse(ctPulse), .irq(irq), .eoaFlag(eoaFlag), .mceFlag(mceFlag),
  .eoaIe(eoaIe), .mceIe(mceIe), .grpDone(grpDone)
);

// File: tb/tb_ct_touch_seq.sv
`timescale 1ns/1ps
module tb_ct_touch_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        syncIn = 1'b0;
  logic [7:0]  sampleIn = '0;
  logic        ctPulse, irq;

  int nChecks = 0;
  int nFail   = 0;
  int thr[8];
  int pCount = 0;
  int hiRun = 0, loRun = 0, lastHi = 0, lastLo = 0;
  bit sawFall = 0;
  logic prevCt = 1'b0;

  always #2.5 clk = ~clk;

  ct_touch_seq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .syncIn(syncIn), .sampleIn(sampleIn),
    .ctPulse(ctPulse), .irq(irq)
  );

  // Pulse monitor and sampling-input model: group g reads high once more than thr[g] pulses began
  always @(negedge clk) begin
    if (ctPulse) begin
      if (!prevCt) begin
        pCount++;
        if (sawFall) lastLo = loRun;
        hiRun = 0;
      end
      hiRun++;
    end else begin
      if (prevCt) begin
        lastHi  = hiRun;
        sawFall = 1;
        loRun   = 0;
      end
      loRun++;
    end
    prevCt = ctPulse;
    for (int g = 0; g < 8; g++) sampleIn[g] = (pCount > thr[g]);
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = rdData;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input bit st, input bit sm, input bit sp,
                                           input logic [2:0] dv, input logic [3:0] hi,
                                           input logic [3:0] lo, input logic [2:0] mc);
    return {14'b0, mc, lo, hi, dv, sp, sm, st, en};
  endfunction

  function automatic int ceilOf(input int mc);
    return (256 << ((mc > 6) ? 6 : mc)) - 1;
  endfunction

  task automatic waitEnd(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      regRead(2, d);
      if (d[1:0] != 2'b00) begin ok = 1; break; end
    end
  endtask

  task automatic armRun();
    @(negedge clk);
    pCount = 0; sawFall = 0; lastHi = 0; lastLo = 0;
  endtask

  // Full acquisition with thr[] already set; checks flags, start bit, completions, counts
  task automatic runCase(input logic [7:0] mask, input logic [2:0] dv, input logic [3:0] hi,
                         input logic [3:0] lo, input logic [2:0] mc);
    logic [31:0] d;
    bit ok, mceExp;
    int cmax;
    logic [7:0] doneExp;
    regWrite(3, 32'h3);
    regWrite(4, {24'b0, mask});
    armRun();
    regWrite(0, ctrlWord(1, 1, 0, 0, dv, hi, lo, mc));
    waitEnd(ok);
    chk("R6 acquisition finished", int'(ok), 1);
    cmax = ceilOf(int'(mc));
    mceExp = 0;
    doneExp = '0;
    for (int g = 0; g < 8; g++) begin
      if (mask[g] && thr[g] >= cmax) mceExp = 1;
      if (mask[g] && thr[g] < cmax) doneExp[g] = 1'b1;
    end
    regRead(2, d);
    if (mceExp) chk("R4 flags on ceiling", int'(d[1:0]), 2);
    else        chk("R5 flags on completion", int'(d[1:0]), 1);
    regRead(0, d);
    chk("R4 R5 start bit cleared", int'(d[1]), 0);
    regRead(4, d);
    chk("R3 completion bits", int'(d[23:16]), int'(doneExp));
    for (int g = 0; g < 8; g++) begin
      int e;
      e = mask[g] ? ((thr[g] < cmax) ? thr[g] : cmax) : 0;
      regRead(8 + g, d);
      chk("R3 R13 group count", int'(d[13:0]), e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int pc;
    void'($urandom(32'd2024));
    for (int g = 0; g < 8; g++) thr[g] = 1000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(0, d); chk("R1 control reset", int'(d), 0);
    regRead(1, d); chk("R1 enables reset", int'(d), 0);
    regRead(2, d); chk("R1 flags reset", int'(d), 0);
    regRead(4, d); chk("R1 group reset", int'(d), 0);
    regRead(8, d); chk("R1 count reset", int'(d), 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 pulse reset", int'(ctPulse), 0);

    // R2 phase timing, divide by 4, high 3, low 2
    for (int g = 0; g < 8; g++) thr[g] = 5;
    runCase(8'h01, 3'd2, 4'd2, 4'd1, 3'd0);
    chk("R2 high width", lastHi, 12);
    chk("R2 low width", lastLo, 8);
    // R2 divide by 1 at the shortest legal low phase
    runCase(8'h81, 3'd0, 4'd0, 4'd2, 3'd0);
    chk("R2 high width div1", lastHi, 1);
    chk("R2 low width div1", lastLo, 3);

    // R10 and R11 on the end-of-acquisition flag left set
    regWrite(1, 32'h1);
    chk("R11 irq on enabled eoa", int'(irq), 1);
    regWrite(1, 32'h2);
    chk("R11 irq masked eoa", int'(irq), 0);
    regWrite(3, 32'h2);
    regRead(2, d); chk("R10 zero bit leaves flag", int'(d[1:0]), 1);
    regWrite(3, 32'h1);
    regRead(2, d); chk("R10 one bit clears flag", int'(d[1:0]), 0);
    regWrite(1, 32'h0);

    // R5 empty mask
    runCase(8'h00, 3'd1, 4'd0, 4'd1, 3'd0);

    // R4 boundary: one group completes on the overflow pulse, another overflows
    thr[0] = 254; thr[1] = 255; thr[2] = 10; thr[3] = 0;
    thr[4] = 400; thr[5] = 3; thr[6] = 254; thr[7] = 100;
    runCase(8'h4F, 3'd1, 4'd0, 4'd1, 3'd0);
    // R4 wider ceiling code 1 (511)
    thr[0] = 510; thr[1] = 300; thr[2] = 511; thr[3] = 7;
    runCase(8'h0F, 3'd1, 4'd0, 4'd1, 3'd1);

    // Randomized acquisitions
    for (int n = 0; n < 8; n++) begin
      logic [7:0] m;
      for (int g = 0; g < 8; g++) thr[g] = int'($urandom_range(299, 0));
      m = 8'($urandom_range(255, 1));
      runCase(m, 3'($urandom_range(2, 1)), 4'($urandom_range(3, 0)),
              4'($urandom_range(3, 1)), 3'd0);
    end

    // R9 illegal divider and low-phase pairs are refused
    for (int g = 0; g < 8; g++) thr[g] = 2;
    regWrite(3, 32'h3);
    regWrite(4, 32'hFF);
    armRun();
    regWrite(0, ctrlWord(1, 1, 0, 0, 3'd0, 4'd0, 4'd1, 3'd0));
    regRead(0, d); chk("R9 div1 low2 refused", int'(d[1]), 0);
    regWrite(0, ctrlWord(1, 1, 0, 0, 3'd1, 4'd0, 4'd0, 3'd0));
    regRead(0, d); chk("R9 div2 low1 refused", int'(d[1]), 0);
    repeat (30) @(negedge clk);
    chk("R9 no pulses", pCount, 0);
    regRead(2, d); chk("R9 no flags", int'(d[1:0]), 0);

    // R7 falling-edge sync: a steady high does not start
    for (int g = 0; g < 8; g++) thr[g] = 3;
    syncIn = 1'b1;
    regWrite(4, 32'h0F);
    armRun();
    regWrite(0, ctrlWord(1, 1, 1, 0, 3'd1, 4'd1, 4'd1, 3'd0));
    repeat (20) @(negedge clk);
    chk("R7 held high does not start", pCount, 0);
    regRead(0, d); chk("R7 start pending", int'(d[1]), 1);
    syncIn = 1'b0;
    waitEnd(ok);
    regRead(2, d); chk("R7 runs after falling edge", int'(d[1:0]), 1);
    regRead(9, d); chk("R7 count after sync", int'(d[13:0]), 3);

    // R8 level sync: low waits, high starts
    regWrite(3, 32'h3);
    armRun();
    regWrite(0, ctrlWord(1, 1, 1, 1, 3'd1, 4'd1, 4'd1, 3'd0));
    repeat (20) @(negedge clk);
    chk("R8 low level waits", pCount, 0);
    syncIn = 1'b1;
    waitEnd(ok);
    regRead(2, d); chk("R8 runs on high", int'(d[1:0]), 1);
    // R8 already-high level starts at once
    regWrite(3, 32'h3);
    armRun();
    regWrite(0, ctrlWord(1, 1, 1, 1, 3'd1, 4'd1, 4'd1, 3'd0));
    repeat (20) @(negedge clk);
    chk("R8 high level starts", int'(pCount > 0), 1);
    waitEnd(ok);
    syncIn = 1'b0;

    // R12 abort mid-run
    for (int g = 0; g < 8; g++) thr[g] = 299;
    regWrite(3, 32'h3);
    regWrite(4, 32'hFF);
    armRun();
    regWrite(0, ctrlWord(1, 1, 0, 0, 3'd1, 4'd1, 4'd1, 3'd0));
    repeat (60) @(negedge clk);
    chk("R12 running before abort", int'(pCount > 0), 1);
    regWrite(0, ctrlWord(0, 0, 0, 0, 3'd1, 4'd1, 4'd1, 3'd0));
    regRead(0, d); chk("R12 start bit cleared", int'(d[1]), 0);
    pc = pCount;
    repeat (40) @(negedge clk);
    chk("R12 pulses stopped", pCount, pc);
    regRead(2, d); chk("R12 no flag on abort", int'(d[1:0]), 0);

    // R13 new start clears the partial counts
    for (int g = 0; g < 8; g++) thr[g] = 0;
    runCase(8'hFF, 3'd1, 4'd0, 4'd1, 3'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule